// File: doc/BRIEF.md
# Unpacked Floating-Point Multiplier

This block multiplies two single-precision operands that an earlier stage has already split into a class, a sign, an unbiased exponent and a significand. It returns the product in the same split form, so a separate rounding and packing stage can consume it. That stage receives a normalized significand carrying three guard bits below the 24 result bits, plus one sticky bit.

For two normal operands, a 24×24 array of partial-product adders forms the full 48-bit product. At most one left shift renormalizes it, and every bit below the kept field collapses into the sticky bit. Every other combination of classes is resolved from per-class one-hot masks:

- infinity times zero
- NaN propagation with a fixed selection rule
- quieting of signaling NaNs
- a default-NaN mode
- infinity results
- zero results

The invalid flag is raised where these cases require it. The result is captured in an output register under a clock enable.

Top module: `fmul_unpacked`

## Requirements
- R1: For every result that is not a NaN, the result sign is the XOR of the two operand signs.
- R2: Both operands of class NORMAL (code 1) have the significand MSB (bit 23) set. The 48-bit product P of the significands is formed, the exponent is ea+eb+1 (11-bit two's complement), the result fraction is P[47:21] and the sticky bit is the OR of P[20:0].
- R3: When P[47] is clear, P is shifted left by one before the field is taken, and the exponent is ea+eb. The fraction MSB (bit 26) of a NORMAL result is therefore always set.
- R4: INF (code 2) times ZERO (code 0), in either order, raises invalid and returns the default NaN. The default NaN has class QNAN (code 3), sign 0, exponent 0, fraction bits [26:3] equal to 0x400000, zero guard bits and sticky 0.
- R5: If exactly one operand is a NaN (QNAN code 3 or SNAN code 4), that operand's sign and 24-bit fraction are passed on. If both are NaNs, the one with the larger fraction wins. On equal fractions the positive one wins, and on a full tie operand a wins. A NaN result has class QNAN, exponent 0, zero guard bits and sticky 0.
- R6: Any SNAN operand raises invalid. A chosen NaN has fraction bit 22 (the quiet bit) set in the result, with all other payload bits kept.
- R7: With default-NaN mode set, any NaN result is replaced by the default NaN. Invalid still follows R4 and R6.
- R8: With no NaN and no infinity-zero pairing, any INF operand gives INF and otherwise any ZERO operand gives ZERO. Both results have exponent 0, fraction 0, sticky 0 and invalid 0.
- R9: The result and valid outputs appear one clock after the enable is sampled high. While the enable is low the result holds and valid is 0. Reset clears all outputs to zero, which is class ZERO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture enable for the result register |
| dflt_nan | input | 1 | Default-NaN mode |
| a_cls | input | 3 | Operand a class (0 zero, 1 normal, 2 inf, 3 qnan, 4 snan) |
| a_sign | input | 1 | Operand a sign |
| a_exp | input | 10 | Operand a unbiased exponent, two's complement |
| a_frac | input | 24 | Operand a significand (NaN payload in bits 22:0) |
| b_cls | input | 3 | Operand b class |
| b_sign | input | 1 | Operand b sign |
| b_exp | input | 10 | Operand b unbiased exponent |
| b_frac | input | 24 | Operand b significand |
| res_cls | output | 3 | Result class |
| res_sign | output | 1 | Result sign |
| res_exp | output | 11 | Result unbiased exponent |
| res_frac | output | 27 | Result significand with three guard bits |
| res_stk | output | 1 | Sticky OR of discarded product bits |
| res_inv | output | 1 | Invalid-operation flag |
| res_vld | output | 1 | Result register was loaded on the last edge |

## Verification
Two functions can meet in one cycle: NaN selection and signaling-NaN quieting collide with default-NaN replacement and with the invalid flag. A case in point is a signaling NaN that loses the selection to a quiet NaN, which must still raise invalid. Directed vectors place two NaNs with equal fractions and opposite signs, a signaling NaN under default-NaN mode, and an infinity-zero pair in both orders. Random vectors mix all five classes so that these pairings recur. Every result field and the invalid flag are compared against a bench model that recomputes the product with a plain multiply and applies the selection rule from the requirements.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  parameter int FRAC_W = 24;
  parameter int EXP_W  = 10;
  parameter int GRD_W  = 3;

  localparam int XW = EXP_W + 1;
  localparam int OW = FRAC_W + GRD_W;
  localparam int PW = 2 * FRAC_W;

  typedef enum logic [2:0] {
    FC_ZERO = 3'd0,
    FC_NORM = 3'd1,
    FC_INF  = 3'd2,
    FC_QNAN = 3'd3,
    FC_SNAN = 3'd4
  } fcls_e;

  localparam logic [FRAC_W-1:0] QUIET_BIT = FRAC_W'(1) << (FRAC_W - 2);

  typedef struct packed {
    fcls_e           cls;
    logic            sign;
    logic [XW-1:0]   exp;
    logic [OW-1:0]   frac;
    logic            stk;
    logic            inv;
  } fres_t;
endpackage

// File: rtl/fmul_sig_path.sv
module fmul_sig_path #(
  parameter int FW = 24,
  parameter int EW = 10,
  parameter int GW = 3
) (
  input  logic [FW-1:0]   ma,
  input  logic [FW-1:0]   mb,
  input  logic [EW-1:0]   ea,
  input  logic [EW-1:0]   eb,
  output logic [FW+GW-1:0] frac,
  output logic            stk,
  output logic [EW:0]     exp
);
  localparam int PWL = 2 * FW;
  localparam int OWL = FW + GW;
  localparam int DW  = PWL - OWL;
  localparam int XWL = EW + 1;

  // partial-product accumulation, one adder row per multiplier bit
  logic [PWL-1:0] acc [0:FW];
  assign acc[0] = '0;

  for (genvar i = 0; i < FW; i++) begin : g_row
    logic [PWL-1:0] pp;
    assign pp         = PWL'(ma & {FW{mb[i]}}) << i;
    assign acc[i + 1] = acc[i] + pp;
  end

  logic [PWL-1:0] prod, shifted;
  logic           renorm;

  always_comb begin
    prod    = acc[FW];
    renorm  = ~prod[PWL-1];
    shifted = renorm ? (prod << 1) : prod;
    frac    = shifted[PWL-1 -: OWL];
    stk     = |shifted[DW-1:0];
    exp     = {ea[EW-1], ea} + {eb[EW-1], eb} + XWL'(1) - XWL'(renorm);
  end

  // p_norm_lead_r3: two normalized significands always yield a normalized field
  always_comb begin
    if (ma[FW-1] && mb[FW-1]) begin
      p_norm_lead_r3: assert (frac[OWL-1]);
    end
  end
endmodule

// File: rtl/fmul_nan_pick.sv
module fmul_nan_pick
  import fmul_pkg::*;
#(
  parameter int FW = FRAC_W
) (
  input  logic [2:0]    a_cls,
  input  logic          a_sign,
  input  logic [FW-1:0] a_frac,
  input  logic [2:0]    b_cls,
  input  logic          b_sign,
  input  logic [FW-1:0] b_frac,
  input  logic          dflt,
  output logic          n_sign,
  output logic [FW-1:0] n_frac,
  output logic          snan_any
);
  localparam logic [FW-1:0] QB = FW'(1) << (FW - 2);

  logic a_nan, b_nan, pick_b, tie_pos_b;
  logic          sel_sign;
  logic [FW-1:0] sel_frac;

  always_comb begin
    a_nan     = (a_cls == FC_QNAN) || (a_cls == FC_SNAN);
    b_nan     = (b_cls == FC_QNAN) || (b_cls == FC_SNAN);
    snan_any  = (a_cls == FC_SNAN) || (b_cls == FC_SNAN);
    tie_pos_b = (b_frac == a_frac) && a_sign && !b_sign;
    pick_b    = b_nan && (!a_nan || (b_frac > a_frac) || tie_pos_b);
    sel_sign  = pick_b ? b_sign : a_sign;
    sel_frac  = pick_b ? b_frac : a_frac;
    if (dflt) begin
      n_sign = 1'b0;
      n_frac = QB;
    end else begin
      n_sign = sel_sign;
      n_frac = sel_frac | QB;
    end
  end
endmodule

// File: rtl/fmul_case_sel.sv
module fmul_case_sel
  import fmul_pkg::*;
(
  input  logic [2:0]    a_cls,
  input  logic          a_sign,
  input  logic [2:0]    b_cls,
  input  logic          b_sign,
  input  logic [OW-1:0] p_frac,
  input  logic          p_stk,
  input  logic [XW-1:0] p_exp,
  input  logic          n_sign,
  input  logic [FRAC_W-1:0] n_frac,
  input  logic          snan_any,
  output fres_t         res
);
  localparam logic [4:0] M_ZERO = 5'b00001;
  localparam logic [4:0] M_NORM = 5'b00010;
  localparam logic [4:0] M_INF  = 5'b00100;
  localparam logic [4:0] M_NAN  = 5'b11000;

  logic [4:0] am, bm, abm;
  logic       psign;

  always_comb begin
    am    = 5'b00001 << a_cls;
    bm    = 5'b00001 << b_cls;
    abm   = am | bm;
    psign = a_sign ^ b_sign;
    res   = '0;
    if (abm == M_NORM) begin
      res.cls  = FC_NORM;
      res.sign = psign;
      res.exp  = p_exp;
      res.frac = p_frac;
      res.stk  = p_stk;
    end else if (abm == (M_INF | M_ZERO)) begin
      res.cls  = FC_QNAN;
      res.frac = {QUIET_BIT, {GRD_W{1'b0}}};
      res.inv  = 1'b1;
    end else if ((abm & M_NAN) != 5'b0) begin
      res.cls  = FC_QNAN;
      res.sign = n_sign;
      res.frac = {n_frac, {GRD_W{1'b0}}};
      res.inv  = snan_any;
    end else if ((abm & M_INF) != 5'b0) begin
      res.cls  = FC_INF;
      res.sign = psign;
    end else begin
      res.cls  = FC_ZERO;
      res.sign = psign;
    end
  end
endmodule

// File: rtl/fmul_unpacked.sv
module fmul_unpacked
  import fmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dflt_nan,
  input  logic [2:0]        a_cls,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [FRAC_W-1:0] a_frac,
  input  logic [2:0]        b_cls,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [FRAC_W-1:0] b_frac,
  output logic [2:0]        res_cls,
  output logic              res_sign,
  output logic [XW-1:0]     res_exp,
  output logic [OW-1:0]     res_frac,
  output logic              res_stk,
  output logic              res_inv,
  output logic              res_vld
);
  logic [OW-1:0]     p_frac;
  logic              p_stk;
  logic [XW-1:0]     p_exp;
  logic              n_sign, snan_any;
  logic [FRAC_W-1:0] n_frac;
  fres_t             res_d, res_q;
  logic              vld_q;

  fmul_sig_path #(.FW(FRAC_W), .EW(EXP_W), .GW(GRD_W)) u_sig (
    .ma(a_frac), .mb(b_frac), .ea(a_exp), .eb(b_exp),
    .frac(p_frac), .stk(p_stk), .exp(p_exp)
  );

  fmul_nan_pick #(.FW(FRAC_W)) u_nan (
    .a_cls(a_cls), .a_sign(a_sign), .a_frac(a_frac),
    .b_cls(b_cls), .b_sign(b_sign), .b_frac(b_frac),
    .dflt(dflt_nan), .n_sign(n_sign), .n_frac(n_frac), .snan_any(snan_any)
  );

  fmul_case_sel u_sel (
    .a_cls(a_cls), .a_sign(a_sign), .b_cls(b_cls), .b_sign(b_sign),
    .p_frac(p_frac), .p_stk(p_stk), .p_exp(p_exp),
    .n_sign(n_sign), .n_frac(n_frac), .snan_any(snan_any),
    .res(res_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= en;
      if (en) begin
        res_q <= res_d;
      end
    end
  end

  assign res_cls  = res_q.cls;
  assign res_sign = res_q.sign;
  assign res_exp  = res_q.exp;
  assign res_frac = res_q.frac;
  assign res_stk  = res_q.stk;
  assign res_inv  = res_q.inv;
  assign res_vld  = vld_q;

  logic a_isnan, b_isnan, inf_zero;
  assign a_isnan  = (a_cls == FC_QNAN) || (a_cls == FC_SNAN);
  assign b_isnan  = (b_cls == FC_QNAN) || (b_cls == FC_SNAN);
  assign inf_zero = ((a_cls == FC_INF) && (b_cls == FC_ZERO)) ||
                    ((a_cls == FC_ZERO) && (b_cls == FC_INF));

  p_sign_xor_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !a_isnan && !b_isnan && !inf_zero) |=> (res_sign == $past(a_sign ^ b_sign)));

  p_norm_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_cls == FC_NORM) |-> res_frac[OW-1]);

  p_inf_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && inf_zero) |=> (res_cls == FC_QNAN && res_inv && !res_sign));

  p_snan_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ((a_cls == FC_SNAN) || (b_cls == FC_SNAN))) |=> res_inv);

  p_no_snan_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_cls != FC_SNAN);

  p_dflt_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dflt_nan && (a_isnan || b_isnan)) |=>
      (res_frac == {QUIET_BIT, {GRD_W{1'b0}}} && !res_sign));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(res_frac) && $stable(res_cls) && $stable(res_exp) && !res_vld));
endmodule

// File: tb/fmul_unpacked_bench.sv
`timescale 1ns/1ps
module fmul_unpacked_bench;
  import fmul_pkg::*;

  logic clk = 1'b0;
  logic rst_n, en, dflt_nan;
  logic [2:0]  a_cls, b_cls;
  logic        a_sign, b_sign;
  logic [9:0]  a_exp, b_exp;
  logic [23:0] a_frac, b_frac;
  logic [2:0]  res_cls;
  logic        res_sign, res_stk, res_inv, res_vld;
  logic [10:0] res_exp;
  logic [26:0] res_frac;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fmul_unpacked u_fmul_unpacked (
    .clk(clk), .rst_n(rst_n), .en(en), .dflt_nan(dflt_nan),
    .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
    .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
    .res_cls(res_cls), .res_sign(res_sign), .res_exp(res_exp),
    .res_frac(res_frac), .res_stk(res_stk), .res_inv(res_inv), .res_vld(res_vld)
  );

  // expected result
  logic [2:0]  x_cls;
  logic        x_sign, x_stk, x_inv;
  logic [10:0] x_exp;
  logic [26:0] x_frac;
  string       x_tag;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  function automatic logic is_nan(input logic [2:0] c);
    return (c == 3'd3) || (c == 3'd4);
  endfunction

  task automatic model();
    logic [47:0] p;
    logic [10:0] e;
    logic        pick_b;
    x_cls = 3'd0; x_sign = 1'b0; x_exp = '0; x_frac = '0; x_stk = 1'b0; x_inv = 1'b0;
    if (a_cls == 3'd1 && b_cls == 3'd1) begin
      p = {24'b0, a_frac} * {24'b0, b_frac};
      e = {a_exp[9], a_exp} + {b_exp[9], b_exp} + 11'd1;
      x_tag = p[47] ? "R2" : "R3";
      if (!p[47]) begin p = p << 1; e = e - 11'd1; end
      x_cls = 3'd1; x_sign = a_sign ^ b_sign; x_exp = e;
      x_frac = p[47:21]; x_stk = |p[20:0];
    end else if ((a_cls == 3'd2 && b_cls == 3'd0) || (a_cls == 3'd0 && b_cls == 3'd2)) begin
      x_tag = "R4"; x_cls = 3'd3; x_frac = {24'h400000, 3'b0}; x_inv = 1'b1;
    end else if (is_nan(a_cls) || is_nan(b_cls)) begin
      x_inv = (a_cls == 3'd4) || (b_cls == 3'd4);
      x_tag = dflt_nan ? "R7" : (x_inv ? "R6" : "R5");
      if (!is_nan(a_cls)) pick_b = 1'b1;
      else if (!is_nan(b_cls)) pick_b = 1'b0;
      else if (b_frac > a_frac) pick_b = 1'b1;
      else if (b_frac < a_frac) pick_b = 1'b0;
      else pick_b = a_sign && !b_sign;
      x_cls = 3'd3;
      if (dflt_nan) x_frac = {24'h400000, 3'b0};
      else begin
        x_sign = pick_b ? b_sign : a_sign;
        x_frac = {(pick_b ? b_frac : a_frac) | 24'h400000, 3'b0};
      end
    end else begin
      x_tag = "R8";
      x_sign = a_sign ^ b_sign;
      x_cls = (a_cls == 3'd2 || b_cls == 3'd2) ? 3'd2 : 3'd0;
    end
  endtask

  task automatic apply(input logic [2:0] ac, input logic as, input logic [9:0] ae, input logic [23:0] af,
                       input logic [2:0] bc, input logic bs, input logic [9:0] be, input logic [23:0] bf,
                       input logic dn);
    @(negedge clk);
    a_cls = ac; a_sign = as; a_exp = ae; a_frac = af;
    b_cls = bc; b_sign = bs; b_exp = be; b_frac = bf;
    dflt_nan = dn; en = 1'b1;
    model();
    @(negedge clk);
    en = 1'b0;
    chk(x_tag, {20'b0, res_cls, res_sign, res_exp, res_frac, res_stk, res_inv},
               {20'b0, x_cls, x_sign, x_exp, x_frac, x_stk, x_inv});
    if (x_cls != 3'd3) chk("R1 sign", {63'b0, res_sign}, {63'b0, x_sign});
    chk("R9 valid", {63'b0, res_vld}, 64'd1);
  endtask

  function automatic logic [23:0] rnd_frac(input logic [2:0] c);
    logic [23:0] f;
    f = 24'($urandom);
    case (c)
      3'd1: f = {1'b1, f[22:0]};
      3'd3: f = {2'b01, f[21:0]};
      3'd4: f = {2'b00, f[21:1], 1'b1};
      default: f = '0;
    endcase
    return f;
  endfunction

  function automatic logic [2:0] rnd_cls();
    int r;
    r = int'($urandom % 16);
    if (r < 9) return 3'd1;
    if (r < 11) return 3'd0;
    if (r < 13) return 3'd2;
    if (r < 15) return 3'd3;
    return 3'd4;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R9: watchdog expired, actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b0; dflt_nan = 1'b0;
    a_cls = '0; a_sign = 0; a_exp = '0; a_frac = '0;
    b_cls = '0; b_sign = 0; b_exp = '0; b_frac = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk("R9 reset", {20'b0, res_cls, res_sign, res_exp, res_frac, res_stk, res_inv, res_vld}, 64'd0);

    // R3: 1.0 * 1.0 needs renormalization
    apply(3'd1, 0, 10'd0, 24'h800000, 3'd1, 0, 10'd0, 24'h800000, 0);
    // R2: largest significands, sticky from bit 0
    apply(3'd1, 1, 10'd127, 24'hFFFFFF, 3'd1, 0, 10'd127, 24'hFFFFFF, 0);
    apply(3'd1, 1, -10'sd149, 24'h800001, 3'd1, 1, -10'sd20, 24'hC00000, 0);
    // R4: infinity times zero both orders
    apply(3'd2, 1, 10'd0, 24'h0, 3'd0, 0, 10'd0, 24'h0, 0);
    apply(3'd0, 1, 10'd0, 24'h0, 3'd2, 1, 10'd0, 24'h0, 0);
    // R5: single quiet NaN, and equal-fraction pair broken toward positive
    apply(3'd3, 1, 10'd0, 24'h4ABCDE, 3'd1, 0, 10'd3, 24'h900000, 0);
    apply(3'd3, 1, 10'd0, 24'h412345, 3'd3, 0, 10'd0, 24'h412345, 0);
    apply(3'd3, 0, 10'd0, 24'h400001, 3'd3, 1, 10'd0, 24'h400002, 0);
    // R6: signaling NaN quieted; signaling loses to larger quiet NaN yet invalid
    apply(3'd4, 0, 10'd0, 24'h000123, 3'd1, 1, 10'd1, 24'h800000, 0);
    apply(3'd4, 0, 10'd0, 24'h000123, 3'd3, 1, 10'd0, 24'h400000, 0);
    // R7: default-NaN mode with signaling and quiet
    apply(3'd4, 1, 10'd0, 24'h000055, 3'd2, 0, 10'd0, 24'h0, 1);
    apply(3'd1, 1, 10'd5, 24'h812345, 3'd3, 1, 10'd0, 24'h6AAAAA, 1);
    // R8: infinity and zero results
    apply(3'd2, 0, 10'd0, 24'h0, 3'd1, 1, 10'd7, 24'hA00000, 0);
    apply(3'd2, 1, 10'd0, 24'h0, 3'd2, 1, 10'd0, 24'h0, 0);
    apply(3'd0, 1, 10'd0, 24'h0, 3'd1, 0, 10'd9, 24'hF00000, 0);

    // R9: enable low holds the previous result
    @(negedge clk);
    a_cls = 3'd1; a_frac = 24'hFFFFFF; b_cls = 3'd4; b_frac = 24'h000001; dflt_nan = 1'b1;
    @(negedge clk);
    chk("R9 hold", {20'b0, res_cls, res_sign, res_exp, res_frac, res_stk, res_inv},
                   {20'b0, x_cls, x_sign, x_exp, x_frac, x_stk, x_inv});
    chk("R9 valid low", {63'b0, res_vld}, 64'd0);

    for (int k = 0; k < 600; k++) begin
      logic [2:0] ca, cb;
      ca = rnd_cls();
      cb = rnd_cls();
      apply(ca, 1'($urandom), 10'($urandom_range(0, 276)) - 10'd149, rnd_frac(ca),
            cb, 1'($urandom), 10'($urandom_range(0, 276)) - 10'd149, rnd_frac(cb),
            ($urandom % 4) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule